// File: doc/BRIEF.md
# Digital Potentiometer Command Engine

This block sits behind a two-wire serial slave front end and carries out the instructions addressed to a bank of four digital potentiometers. Each pot owns an 8-bit wiper register, whose low six bits give the tap position and whose top two bits are carried along unchanged, and four 8-bit nonvolatile data registers. The front end hands over a decoded command byte once the slave address has matched. For write commands it then hands over one data byte. During a step session it hands over single step pulses. It gets back an accept strobe, which it turns into the acknowledge bit, read data for the two read commands, and a busy flag.

Writes that land in a data register model a nonvolatile write. They start a busy window whose length is a parameter counted in system clock cycles. New commands are refused while the window is open. Loads of a wiper register take effect at once. The data registers keep their contents through the synchronous reset. At reset every wiper register reloads from data register 0 of its own pot. The data registers power up with a computed factory image.

Top module: `pot_cmd_engine`

## Requirements
- R1: The command byte is split as opcode = bits 7:4, pot = bits 3:2, register = bits 1:0. A command presented on `cmd_valid` while `busy` is low is accepted, and `cmd_ack` is high for exactly the one cycle after it.
- R2: Opcode 1001 returns the selected pot's wiper register, and opcode 1011 returns the selected data register. `rd_valid` pulses and `rd_data` holds the value in the cycle after acceptance.
- R3: Opcode 1010 followed by one `wr_valid` byte loads that byte into the selected wiper register at that edge. It starts no busy window.
- R4: Opcode 1100 followed by one `wr_valid` byte writes the selected data register. `busy` is then high for exactly BUSY_CYCLES cycles after the data edge.
- R5: Opcode 1101 copies the selected data register of the selected pot into that pot's wiper register. No other pot changes and no busy window starts.
- R6: Opcode 1110 copies the selected pot's wiper register into its selected data register and starts a busy window.
- R7: Opcode 0001 ignores the pot bits and loads every pot's wiper register from that pot's data register chosen by bits 1:0.
- R8: Opcode 1000 ignores the pot bits, copies every wiper register into its own pot's data register chosen by bits 1:0, and starts a busy window.
- R9: Opcode 0010 opens a step session on the selected pot. Each `step_valid` pulse moves the low six bits of that wiper register up by one (`step_up`=1) or down by one (`step_up`=0). The value saturates at 0 and 63, bits 7:6 are kept, and the session ends at the next accepted command.
- R10: While `busy` is high, commands are not acknowledged and have no effect, and a data byte that follows a refused command changes nothing.
- R11: Opcodes 0000, 0011 to 0111 and 1111 are acknowledged but change no register. A data byte that follows them is ignored.
- R12: Data register r of pot p powers up holding (16·p + 5·r + 3) mod 64. Reset clears `busy`, keeps the data registers, and loads each wiper register from data register 0 of its own pot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command byte present for one cycle |
| cmd_byte | input | 8 | Opcode, pot select, register select |
| wr_valid | input | 1 | Data byte of a write command present |
| wr_data | input | 8 | Data byte of a write command |
| step_valid | input | 1 | One step pulse in a step session |
| step_up | input | 1 | Step direction: 1 up, 0 down |
| cmd_ack | output | 1 | Command accepted (one cycle) |
| busy | output | 1 | Nonvolatile write window open |
| rd_valid | output | 1 | Read data valid (one cycle) |
| rd_data | output | 8 | Read result |
| wipers | output | 32 | Wiper registers, pot p at bits 8p+7:8p |

## Verification
The bench builds the engine with BUSY_CYCLES set to 5. At that size the full length of every busy window can be counted cycle by cycle, and refused commands can be placed well inside an open window. The short window also makes sweeps affordable over all sixteen pot and register pairs for writes, reads and transfers, and over every unlisted opcode with every select value. Step sessions are run past both ends of the tap range, so saturation and the kept top bits are covered.

// File: rtl/pot_pkg.sv
`timescale 1ns/1ps
package pot_pkg;
    localparam int NPOT  = 4;
    localparam int NREG  = 4;
    localparam int DW    = 8;
    localparam int POSW  = 6;
    localparam logic [POSW-1:0] POS_MAX = '1;

    typedef enum logic [3:0] {
        OP_NOP    = 4'b0000,
        OP_G_D2W  = 4'b0001,
        OP_STEP   = 4'b0010,
        OP_G_W2D  = 4'b1000,
        OP_RD_WIP = 4'b1001,
        OP_WR_WIP = 4'b1010,
        OP_RD_DAT = 4'b1011,
        OP_WR_DAT = 4'b1100,
        OP_D2W    = 4'b1101,
        OP_W2D    = 4'b1110
    } opcode_e;

    typedef struct packed {
        opcode_e    op;
        logic [1:0] pot;
        logic [1:0] sel;
    } cmd_t;

    typedef enum logic [1:0] {
        PEND_NONE,
        PEND_WIP,
        PEND_DAT,
        PEND_STEP
    } pend_e;

    typedef enum logic [1:0] {
        WOP_HOLD,
        WOP_LOAD,
        WOP_UP,
        WOP_DOWN
    } wop_e;

    typedef struct packed {
        wop_e          wop;
        logic [DW-1:0] wval;
        logic          dwe;
        logic [1:0]    dsel;
        logic [DW-1:0] dval;
    } pot_ctl_t;

    function automatic logic [DW-1:0] factory_value(int p, int r);
        int v;
        v = (p * 16 + r * 5 + 3) % 64;
        return DW'(v);
    endfunction

    function automatic logic [NREG-1:0][DW-1:0] factory_bank(int p);
        logic [NREG-1:0][DW-1:0] b;
        for (int r = 0; r < NREG; r++) b[r] = factory_value(p, r);
        return b;
    endfunction

    function automatic cmd_t decode_cmd(logic [7:0] b);
        cmd_t c;
        c.pot = b[3:2];
        c.sel = b[1:0];
        case (b[7:4])
            4'b0001, 4'b0010, 4'b1000, 4'b1001, 4'b1010,
            4'b1011, 4'b1100, 4'b1101, 4'b1110: c.op = opcode_e'(b[7:4]);
            default:                            c.op = OP_NOP;
        endcase
        return c;
    endfunction
endpackage

// File: rtl/pot_busy_timer.sv
`timescale 1ns/1ps
module pot_busy_timer #(
    parameter int CYCLES = 2000
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    output logic busy
);
    localparam int CW = $clog2(CYCLES + 1);
    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)             cnt <= '0;
        else if (start)      cnt <= CW'(CYCLES);
        else if (cnt != '0)  cnt <= cnt - 1'b1;
    end

    assign busy = (cnt != '0);
endmodule

// File: rtl/pot_slice.sv
`timescale 1ns/1ps
module pot_slice
    import pot_pkg::*;
#(
    parameter int POT_IDX = 0
) (
    input  logic                    clk,
    input  logic                    rst,
    input  pot_ctl_t                ctl,
    output logic [DW-1:0]           wiper,
    output logic [NREG-1:0][DW-1:0] dregs
);
    logic [NREG-1:0][DW-1:0] bank = factory_bank(POT_IDX);
    logic [POSW-1:0]         pos;

    assign pos   = wiper[POSW-1:0];
    assign dregs = bank;

    always_ff @(posedge clk) begin
        if (ctl.dwe) bank[ctl.dsel] <= ctl.dval;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wiper <= bank[0];
        end else begin
            case (ctl.wop)
                WOP_LOAD: wiper <= ctl.wval;
                WOP_UP:   if (pos != POS_MAX) wiper[POSW-1:0] <= pos + 1'b1;
                WOP_DOWN: if (pos != '0)      wiper[POSW-1:0] <= pos - 1'b1;
                default:  ;
            endcase
        end
    end
endmodule

// File: rtl/pot_ctl_gen.sv
`timescale 1ns/1ps
module pot_ctl_gen
    import pot_pkg::*;
(
    input  logic                              accept,
    input  cmd_t                              cmd,
    input  logic                              wr_valid,
    input  logic [DW-1:0]                     wr_data,
    input  logic                              step_valid,
    input  logic                              step_up,
    input  pend_e                             pend_op,
    input  logic [1:0]                        pend_pot,
    input  logic [1:0]                        pend_sel,
    input  logic [NPOT-1:0][DW-1:0]           wip_all,
    input  logic [NPOT-1:0][NREG-1:0][DW-1:0] dat_all,
    output pot_ctl_t [NPOT-1:0]               ctl,
    output logic                              busy_start
);
    always_comb begin
        for (int p = 0; p < NPOT; p++) begin
            ctl[p].wop  = WOP_HOLD;
            ctl[p].wval = '0;
            ctl[p].dwe  = 1'b0;
            ctl[p].dsel = '0;
            ctl[p].dval = '0;
            if (accept) begin
                case (cmd.op)
                    OP_D2W, OP_G_D2W: begin
                        if (cmd.op == OP_G_D2W || cmd.pot == 2'(p)) begin
                            ctl[p].wop  = WOP_LOAD;
                            ctl[p].wval = dat_all[p][cmd.sel];
                        end
                    end
                    OP_W2D, OP_G_W2D: begin
                        if (cmd.op == OP_G_W2D || cmd.pot == 2'(p)) begin
                            ctl[p].dwe  = 1'b1;
                            ctl[p].dsel = cmd.sel;
                            ctl[p].dval = wip_all[p];
                        end
                    end
                    default: ;
                endcase
            end else if (wr_valid && pend_pot == 2'(p)) begin
                if (pend_op == PEND_WIP) begin
                    ctl[p].wop  = WOP_LOAD;
                    ctl[p].wval = wr_data;
                end else if (pend_op == PEND_DAT) begin
                    ctl[p].dwe  = 1'b1;
                    ctl[p].dsel = pend_sel;
                    ctl[p].dval = wr_data;
                end
            end else if (step_valid && pend_op == PEND_STEP && pend_pot == 2'(p)) begin
                ctl[p].wop = step_up ? WOP_UP : WOP_DOWN;
            end
        end
        busy_start = (accept && (cmd.op == OP_W2D || cmd.op == OP_G_W2D)) ||
                     (!accept && wr_valid && pend_op == PEND_DAT);
    end
endmodule

// File: rtl/pot_cmd_engine.sv
`timescale 1ns/1ps
module pot_cmd_engine
    import pot_pkg::*;
#(
    parameter int BUSY_CYCLES = 2000
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         cmd_valid,
    input  logic [7:0]   cmd_byte,
    input  logic         wr_valid,
    input  logic [7:0]   wr_data,
    input  logic         step_valid,
    input  logic         step_up,
    output logic         cmd_ack,
    output logic         busy,
    output logic         rd_valid,
    output logic [7:0]   rd_data,
    output logic [31:0]  wipers
);
    cmd_t                              cmd;
    logic                              accept, wr_ok, step_ok, busy_start;
    pend_e                             pend_op;
    logic [1:0]                        pend_pot, pend_sel;
    pot_ctl_t [NPOT-1:0]               ctl;
    logic [NPOT-1:0][DW-1:0]           wip_all;
    logic [NPOT-1:0][NREG-1:0][DW-1:0] dat_all;

    assign cmd     = decode_cmd(cmd_byte);
    assign accept  = cmd_valid && !busy && !rst;
    assign wr_ok   = wr_valid && !rst;
    assign step_ok = step_valid && !rst;

    pot_busy_timer #(.CYCLES(BUSY_CYCLES)) u_timer (
        .clk   (clk),
        .rst   (rst),
        .start (busy_start),
        .busy  (busy)
    );

    pot_ctl_gen u_ctl (
        .accept     (accept),
        .cmd        (cmd),
        .wr_valid   (wr_ok),
        .wr_data    (wr_data),
        .step_valid (step_ok),
        .step_up    (step_up),
        .pend_op    (pend_op),
        .pend_pot   (pend_pot),
        .pend_sel   (pend_sel),
        .wip_all    (wip_all),
        .dat_all    (dat_all),
        .ctl        (ctl),
        .busy_start (busy_start)
    );

    for (genvar p = 0; p < NPOT; p++) begin : g_pot
        pot_slice #(.POT_IDX(p)) u_slice (
            .clk   (clk),
            .rst   (rst),
            .ctl   (ctl[p]),
            .wiper (wip_all[p]),
            .dregs (dat_all[p])
        );
        assign wipers[DW*p +: DW] = wip_all[p];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_op  <= PEND_NONE;
            pend_pot <= '0;
            pend_sel <= '0;
        end else if (accept) begin
            pend_pot <= cmd.pot;
            pend_sel <= cmd.sel;
            case (cmd.op)
                OP_WR_WIP: pend_op <= PEND_WIP;
                OP_WR_DAT: pend_op <= PEND_DAT;
                OP_STEP:   pend_op <= PEND_STEP;
                default:   pend_op <= PEND_NONE;
            endcase
        end else if (wr_ok && (pend_op == PEND_WIP || pend_op == PEND_DAT)) begin
            pend_op <= PEND_NONE;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cmd_ack  <= 1'b0;
            rd_valid <= 1'b0;
            rd_data  <= '0;
        end else begin
            cmd_ack  <= accept;
            rd_valid <= accept && (cmd.op == OP_RD_WIP || cmd.op == OP_RD_DAT);
            if (accept && cmd.op == OP_RD_WIP)      rd_data <= wip_all[cmd.pot];
            else if (accept && cmd.op == OP_RD_DAT) rd_data <= dat_all[cmd.pot][cmd.sel];
        end
    end
endmodule

// File: rtl/pot_cmd_engine_chk.sv
`timescale 1ns/1ps
module pot_cmd_engine_chk (
    input logic        clk,
    input logic        rst,
    input logic        cmd_valid,
    input logic [7:0]  cmd_byte,
    input logic        cmd_ack,
    input logic        busy,
    input logic        rd_valid,
    input logic [31:0] wipers
);
    logic take;
    assign take = cmd_valid && !busy;

    // R1
    p_ack_follows_cmd_r1: assert property (@(posedge clk) disable iff (rst)
        cmd_ack |-> $past(take));

    // R10
    p_no_ack_when_busy_r10: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && busy) |=> !cmd_ack);

    // R2
    p_read_gives_data_r2: assert property (@(posedge clk) disable iff (rst)
        (take && (cmd_byte[7:4] == 4'b1001 || cmd_byte[7:4] == 4'b1011)) |=> rd_valid);

    // R5
    p_load_wiper_no_busy_r5: assert property (@(posedge clk) disable iff (rst)
        (take && cmd_byte[7:4] == 4'b1101) |=> !busy);

    // R6
    p_store_wiper_busy_r6: assert property (@(posedge clk) disable iff (rst)
        (take && cmd_byte[7:4] == 4'b1110) |=> busy);

    // R8
    p_global_store_busy_r8: assert property (@(posedge clk) disable iff (rst)
        (take && cmd_byte[7:4] == 4'b1000) |=> busy);

    // R11
    p_unlisted_no_change_r11: assert property (@(posedge clk) disable iff (rst)
        (take && cmd_byte[7:4] == 4'b0000) |=> ($stable(wipers) && !busy));
endmodule

bind pot_cmd_engine pot_cmd_engine_chk u_chk (.*);

// File: tb/tb_pot_cmd_engine.sv
`timescale 1ns/1ps
module tb_pot_cmd_engine;
    localparam int BC = 5;

    logic        clk = 1'b0;
    logic        rst;
    logic        cmd_valid, wr_valid, step_valid, step_up;
    logic [7:0]  cmd_byte, wr_data;
    logic        cmd_ack, busy, rd_valid;
    logic [7:0]  rd_data;
    logic [31:0] wipers;

    int total = 0;
    int bad   = 0;
    logic [7:0] mw [4];
    logic [7:0] md [4][4];

    always #4 clk = ~clk;

    pot_cmd_engine #(.BUSY_CYCLES(BC)) dut (
        .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_byte(cmd_byte),
        .wr_valid(wr_valid), .wr_data(wr_data), .step_valid(step_valid),
        .step_up(step_up), .cmd_ack(cmd_ack), .busy(busy),
        .rd_valid(rd_valid), .rd_data(rd_data), .wipers(wipers)
    );

    function automatic logic [7:0] fv(int p, int r);
        return 8'((p * 16 + r * 5 + 3) % 64);
    endfunction

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s act=%0h exp=%0h", req, what, act, exp);
        end
    endtask

    task automatic send_cmd(input logic [7:0] b);
        cmd_valid = 1'b1; cmd_byte = b;
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    task automatic send_dat(input logic [7:0] d);
        wr_valid = 1'b1; wr_data = d;
        @(negedge clk);
        wr_valid = 1'b0;
    endtask

    task automatic do_step(input logic up);
        step_valid = 1'b1; step_up = up;
        @(negedge clk);
        step_valid = 1'b0;
    endtask

    task automatic wait_idle();
        while (busy) @(negedge clk);
    endtask

    task automatic check_wipers(input string req);
        for (int p = 0; p < 4; p++) chk(req, "wiper", wipers[8*p +: 8], mw[p]);
    endtask

    task automatic rd_dat(input int p, input int r, input string req);
        send_cmd({4'b1011, 2'(p), 2'(r)});
        chk(req, "rd_valid", rd_valid, 1);
        chk(req, "rd_data", rd_data, md[p][r]);
    endtask

    task automatic write_wiper(input int p, input logic [7:0] v);
        send_cmd({4'b1010, 2'(p), 2'b00});
        chk("R1", "ack", cmd_ack, 1);
        send_dat(v);
        mw[p] = v;
        chk("R3", "busy", busy, 0);
        check_wipers("R3");
    endtask

    task automatic write_dreg(input int p, input int r, input logic [7:0] v);
        int n;
        send_cmd({4'b1100, 2'(p), 2'(r)});
        chk("R1", "ack", cmd_ack, 1);
        send_dat(v);
        md[p][r] = v;
        n = 0;
        while (busy) begin n++; @(negedge clk); end
        chk("R4", "busy length", n, BC);
    endtask

    initial begin
        #1200000;
        total++; bad++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int n;
        logic [7:0] e;
        rst = 1'b1; cmd_valid = 0; wr_valid = 0; step_valid = 0; step_up = 0;
        cmd_byte = '0; wr_data = '0;
        for (int p = 0; p < 4; p++) begin
            for (int r = 0; r < 4; r++) md[p][r] = fv(p, r);
            mw[p] = fv(p, 0);
        end
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R12: reset state
        chk("R12", "busy", busy, 0);
        chk("R1", "ack at reset", cmd_ack, 0);
        chk("R2", "rd_valid at reset", rd_valid, 0);
        check_wipers("R12");
        for (int p = 0; p < 4; p++)
            for (int r = 0; r < 4; r++) rd_dat(p, r, "R12");

        // R2: read wipers
        for (int p = 0; p < 4; p++) begin
            send_cmd({4'b1001, 2'(p), 2'b11});
            chk("R2", "rd_valid", rd_valid, 1);
            chk("R2", "rd wiper", rd_data, mw[p]);
        end

        // R3: write wiper sweep
        for (int p = 0; p < 4; p++)
            for (int k = 0; k < 4; k++) write_wiper(p, 8'(p * 53 + k * 71 + 9));

        // R4: write all data registers, read back
        for (int p = 0; p < 4; p++)
            for (int r = 0; r < 4; r++) write_dreg(p, r, 8'(p * 37 + r * 11 + 128));
        for (int p = 0; p < 4; p++)
            for (int r = 0; r < 4; r++) rd_dat(p, r, "R4");

        // R10: commands while busy are refused
        send_cmd({4'b1100, 2'd1, 2'd2});
        send_dat(8'h3C);
        md[1][2] = 8'h3C;
        chk("R10", "busy", busy, 1);
        send_cmd({4'b1010, 2'd0, 2'd0});
        chk("R10", "ack while busy", cmd_ack, 0);
        send_dat(8'h55);
        check_wipers("R10");
        send_cmd({4'b1011, 2'd1, 2'd2});
        chk("R10", "ack read while busy", cmd_ack, 0);
        chk("R10", "rd_valid while busy", rd_valid, 0);
        wait_idle();
        rd_dat(1, 2, "R10");

        // R5: single data->wiper transfer
        for (int p = 0; p < 4; p++)
            for (int r = 0; r < 4; r++) begin
                send_cmd({4'b1101, 2'(p), 2'(r)});
                mw[p] = md[p][r];
                chk("R5", "ack", cmd_ack, 1);
                chk("R5", "busy", busy, 0);
                check_wipers("R5");
            end

        // R6: single wiper->data transfer
        for (int p = 0; p < 4; p++) begin
            write_wiper(p, 8'(p * 19 + 200));
            send_cmd({4'b1110, 2'(p), 2'(3 - p)});
            md[p][3 - p] = mw[p];
            chk("R6", "busy", busy, 1);
            wait_idle();
            for (int r = 0; r < 4; r++) rd_dat(p, r, "R6");
        end

        // R7: global data->wiper, pot bits varied
        for (int r = 0; r < 4; r++) begin
            send_cmd({4'b0001, 2'(r + 1), 2'(r)});
            for (int p = 0; p < 4; p++) mw[p] = md[p][r];
            chk("R7", "busy", busy, 0);
            check_wipers("R7");
        end

        // R8: global wiper->data
        for (int r = 0; r < 4; r++) begin
            for (int p = 0; p < 4; p++) write_wiper(p, 8'(r * 64 + p * 13 + 5));
            send_cmd({4'b1000, 2'(3 - r), 2'(r)});
            for (int p = 0; p < 4; p++) md[p][r] = mw[p];
            chk("R8", "busy", busy, 1);
            wait_idle();
            for (int p = 0; p < 4; p++) rd_dat(p, r, "R8");
        end

        // R9: step session with saturation at both ends
        write_wiper(2, 8'hC2);
        send_cmd({4'b0010, 2'd2, 2'd0});
        chk("R9", "ack", cmd_ack, 1);
        for (int k = 0; k < 3; k++) begin
            do_step(1'b0);
            e = mw[2];
            if (e[5:0] != 6'd0) e[5:0] = e[5:0] - 6'd1;
            mw[2] = e;
            check_wipers("R9");
        end
        for (int k = 0; k < 70; k++) begin
            do_step(1'b1);
            e = mw[2];
            if (e[5:0] != 6'd63) e[5:0] = e[5:0] + 6'd1;
            mw[2] = e;
            chk("R9", "step up", wipers[23:16], mw[2]);
        end
        chk("R9", "top value", wipers[23:16], 8'hFF);
        send_cmd({4'b1001, 2'd2, 2'd0});
        do_step(1'b0);
        check_wipers("R9");

        // R11: unlisted opcodes
        for (int k = 0; k < 7; k++) begin
            logic [3:0] op;
            op = (k == 0) ? 4'b0000 : (k == 6) ? 4'b1111 : 4'(k + 2);
            for (int s = 0; s < 16; s++) begin
                send_cmd({op, 4'(s)});
                chk("R11", "ack", cmd_ack, 1);
                chk("R11", "busy", busy, 0);
                check_wipers("R11");
                send_dat(8'hFF);
                check_wipers("R11");
            end
        end
        for (int p = 0; p < 4; p++)
            for (int r = 0; r < 4; r++) rd_dat(p, r, "R11");

        // R12: reset reloads wipers from register 0, data kept
        for (int p = 0; p < 4; p++) write_dreg(p, 0, 8'(p * 29 + 77));
        for (int p = 0; p < 4; p++) write_wiper(p, 8'(p + 1));
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        for (int p = 0; p < 4; p++) mw[p] = md[p][0];
        chk("R12", "busy after reset", busy, 0);
        check_wipers("R12");
        for (int p = 0; p < 4; p++)
            for (int r = 0; r < 4; r++) rd_dat(p, r, "R12");

        n = 0;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule